// File: doc/BRIEF.md
# Adaptive Slope Delta Encoder

This block turns a stream of signed 16-bit samples into a one-bit-per-sample code. For each accepted sample it compares the input with an internal running estimate and emits a single bit. A 1 means the input is at or above the estimate, and a 0 means it is below. The estimate then moves up or down by the current step. The coded stream therefore runs at exactly the input sample rate. At a 13 kHz sample strobe this gives a 13 kbps voice channel.

The step size adapts to the signal. A run detector watches the most recent output bits. A long run of identical bits shows that the estimate cannot keep pace with a steep input. In that case the step is enlarged by a fixed amount. Without such a run, the step shrinks slowly so that quiet passages are coded with fine resolution. The step is always kept between two bounds fixed by parameters. The estimate saturates at the signed 16-bit limits. A matching decoder that rebuilds the same estimate from the bits sits outside this block.

Top module: `slope_dm_encoder`

## Requirements
- R1: Every cycle with `smp_valid` high produces `code_valid` high on the following cycle, together with one code bit; `code_valid` is low in every other cycle.
- R2: The code bit is 1 when the signed sample is greater than or equal to the current estimate, and 0 when it is smaller (a tie gives 1).
- R3: After a 1 the estimate becomes the previous estimate plus the current step; after a 0 it becomes the previous estimate minus the current step.
- R4: The estimate saturates at +32767 and -32768 instead of wrapping.
- R5: When the new bit and the two bits before it are all equal (at least three bits since reset), the step grows by STEP_INC (default 64), limited to STEP_MAX (default 4096).
- R6: In every other coded cycle the step becomes step - (step >> 5), limited below by STEP_MIN (default 16).
- R7: A synchronous active-low reset sets the estimate to 0, the step to STEP_MIN, empties the bit history, and drives `code_valid` and `code_bit` to 0.
- R8: While `smp_valid` is low, the estimate, the step and the bit history do not change, and `code_bit` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | The sample on `smp_data` is taken in this cycle |
| smp_data | input | 16 | Signed two's-complement input sample |
| code_valid | output | 1 | Strobe marking a new code bit |
| code_bit | output | 1 | Delta code bit for the last accepted sample |

## Verification
On every cycle, the assertions check several properties. The code strobe must follow the sample strobe by one cycle. The estimate must move in the direction of the bit it emitted. The step must stay within its bounds, grow when a run is detected and decay otherwise. Idle cycles must leave the state untouched. Only the bench scenarios can show the exact values involved. These are the tie rule, the precise decay arithmetic, saturation rather than wrap at the 16-bit rails, and the three-bit fill rule after reset. The bench observes all of these through the emitted bit sequence, compared against an independent model.

// File: rtl/sdm_pkg.sv
// Package: shared types and helpers for the adaptive slope delta encoder.
// Assumes: sample words are signed two's complement; steps are unsigned.
package sdm_pkg;

    // Step adaptation decision taken in a coded cycle
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_GROW  = 2'd1,
        STEP_DECAY = 2'd2
    } step_act_e;

endpackage

// File: rtl/sdm_comparator.sv
// Module: sdm_comparator
// Decides the code bit: 1 when the sample is at or above the estimate.
// Assumes: both operands are signed and of equal width.
module sdm_comparator #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic signed [DATA_W-1:0] est_i,
    output logic                     bit_o
);

    // Signed compare, ties give a 1
    always_comb begin
        bit_o = (sample_i >= est_i);
    end

endmodule

// File: rtl/sdm_run_detect.sv
// Module: sdm_run_detect
// Keeps the last HIST_LEN-1 code bits and flags a run when they and the
// new bit are all equal. No run is flagged until the history is full.
// Assumes: HIST_LEN >= 2; bit_i is valid whenever valid_i is high.
module sdm_run_detect #(
    parameter int HIST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic bit_i,
    output logic run_o
);

    localparam int PREV_W = HIST_LEN - 1;
    localparam int FILL_W = $clog2(HIST_LEN) + 1;
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(PREV_W);

    logic [PREV_W-1:0] prev_q;
    logic [FILL_W-1:0] fill_q;
    logic [HIST_LEN-1:0] window;

    // Window made of the stored bits and the new bit
    always_comb begin
        window = {prev_q, bit_i};
        run_o  = (fill_q == FILL_FULL) && ((&window) || (~|window));
    end

    // Shift the new bit in and count history fill up to full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            fill_q <= '0;
        end else if (valid_i) begin
            prev_q <= window[PREV_W-1:0];
            if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
        end
    end

    p_hist_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (fill_q == '0 && prev_q == '0));

    p_hist_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(prev_q) && $stable(fill_q)));

endmodule

// File: rtl/sdm_step_adapt.sv
// Module: sdm_step_adapt
// Holds the step size; grows it by a fixed amount on a run, otherwise
// decays it by step >> DECAY_SHIFT, always clamped to [STEP_MIN, STEP_MAX].
// Assumes: STEP_MIN <= STEP_MAX and both fit in STEP_W bits.
module sdm_step_adapt
    import sdm_pkg::*;
#(
    parameter int STEP_W      = 16,
    parameter int STEP_INC    = 64,
    parameter int STEP_MIN    = 16,
    parameter int STEP_MAX    = 4096,
    parameter int DECAY_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              run_i,
    output logic [STEP_W-1:0] step_o
);

    localparam logic [STEP_W:0] MIN_W = (STEP_W+1)'(STEP_MIN);
    localparam logic [STEP_W:0] MAX_W = (STEP_W+1)'(STEP_MAX);
    localparam logic [STEP_W:0] INC_W = (STEP_W+1)'(STEP_INC);

    logic [STEP_W-1:0] step_q;
    logic [STEP_W:0]   grown;
    logic [STEP_W:0]   decayed;
    logic [STEP_W-1:0] step_d;
    step_act_e         act;

    // Pick the adaptation action for this cycle
    always_comb begin
        if (!valid_i)   act = STEP_HOLD;
        else if (run_i) act = STEP_GROW;
        else            act = STEP_DECAY;
    end

    // Candidate values with clamping, then select by action
    always_comb begin
        grown   = {1'b0, step_q} + INC_W;
        decayed = {1'b0, step_q} - ({1'b0, step_q} >> DECAY_SHIFT);
        if (grown > MAX_W)   grown   = MAX_W;
        if (decayed < MIN_W) decayed = MIN_W;
        case (act)
            STEP_GROW:  step_d = grown[STEP_W-1:0];
            STEP_DECAY: step_d = decayed[STEP_W-1:0];
            default:    step_d = step_q;
        endcase
    end

    // Step register, starts at the minimum
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= MIN_W[STEP_W-1:0];
        else        step_q <= step_d;
    end

    assign step_o = step_q;

    p_step_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (step_q == MIN_W[STEP_W-1:0]));

    p_step_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, step_q} >= MIN_W) && ({1'b0, step_q} <= MAX_W));

    p_step_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && run_i) |=> (step_q >= $past(step_q)));

    p_step_decay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !run_i) |=> (step_q <= $past(step_q)));

    p_step_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(step_q));

endmodule

// File: rtl/sdm_integrator.sv
// Module: sdm_integrator
// Running estimate: adds the step after a 1, subtracts it after a 0,
// and saturates at the signed DATA_W limits.
// Assumes: step_i is unsigned and narrower than 2^DATA_W.
module sdm_integrator #(
    parameter int DATA_W = 16,
    parameter int STEP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic                     bit_i,
    input  logic [STEP_W-1:0]        step_i,
    output logic signed [DATA_W-1:0] est_o
);

    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] TOP = SUM_W'((2 ** (DATA_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] BOT = -SUM_W'(2 ** (DATA_W-1));

    logic signed [DATA_W-1:0] est_q;
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  step_ext;
    logic signed [DATA_W-1:0] est_d;

    // Widened move and clamp to the rails
    always_comb begin
        step_ext = $signed({{(SUM_W-STEP_W){1'b0}}, step_i});
        sum      = bit_i ? (SUM_W'(est_q) + step_ext) : (SUM_W'(est_q) - step_ext);
        if (sum > TOP)      est_d = TOP[DATA_W-1:0];
        else if (sum < BOT) est_d = BOT[DATA_W-1:0];
        else                est_d = sum[DATA_W-1:0];
    end

    // Estimate register, cleared to zero
    always_ff @(posedge clk) begin
        if (!rst_n)       est_q <= '0;
        else if (valid_i) est_q <= est_d;
    end

    assign est_o = est_q;

    p_est_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (est_q == '0));

    p_est_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && bit_i) |=> (est_q >= $past(est_q)));

    p_est_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !bit_i) |=> (est_q <= $past(est_q)));

    p_est_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(est_q));

endmodule

// File: rtl/slope_dm_encoder.sv
// Module: slope_dm_encoder (top)
// One-bit adaptive delta encoder: compare, emit a bit, move the estimate,
// adapt the step from runs of equal bits. The bit is registered and
// appears one cycle after the sample strobe.
// Assumes: one sample per smp_valid cycle; synchronous active-low reset.
module slope_dm_encoder #(
    parameter int DATA_W      = 16,
    parameter int HIST_LEN    = 3,
    parameter int STEP_INC    = 64,
    parameter int STEP_MIN    = 16,
    parameter int STEP_MAX    = 4096,
    parameter int DECAY_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              code_valid,
    output logic              code_bit
);

    localparam int STEP_W = DATA_W;

    logic signed [DATA_W-1:0] est;
    logic [STEP_W-1:0]        step;
    logic                     new_bit;
    logic                     run;

    sdm_comparator #(.DATA_W(DATA_W)) u_cmp (
        .sample_i (signed'(smp_data)),
        .est_i    (est),
        .bit_o    (new_bit)
    );

    sdm_run_detect #(.HIST_LEN(HIST_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (smp_valid),
        .bit_i   (new_bit),
        .run_o   (run)
    );

    sdm_step_adapt #(
        .STEP_W      (STEP_W),
        .STEP_INC    (STEP_INC),
        .STEP_MIN    (STEP_MIN),
        .STEP_MAX    (STEP_MAX),
        .DECAY_SHIFT (DECAY_SHIFT)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (smp_valid),
        .run_i   (run),
        .step_o  (step)
    );

    sdm_integrator #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (smp_valid),
        .bit_i   (new_bit),
        .step_i  (step),
        .est_o   (est)
    );

    // Output register: strobe every cycle, bit only on coded cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code_bit   <= 1'b0;
        end else begin
            code_valid <= smp_valid;
            if (smp_valid) code_bit <= new_bit;
        end
    end

    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> code_valid);

    p_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !code_valid);

    p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(code_bit));

endmodule

// File: tb/slope_dm_encoder_test.sv
// Bench: directed corners plus seeded random samples, checked bit by bit
// against a behavioural model of the encoder kept in bench variables.
module slope_dm_encoder_test;

    localparam int CLK_P    = 10;
    localparam int M_INC    = 64;
    localparam int M_MIN    = 16;
    localparam int M_MAX    = 4096;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        code_valid;
    logic        code_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int   m_est;
    int   m_step;
    logic [1:0] m_hist;
    int   m_fill;
    logic m_last;

    slope_dm_encoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .code_valid (code_valid),
        .code_bit   (code_bit)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic void model_reset();
        m_est  = 0;
        m_step = M_MIN;
        m_hist = 2'b00;
        m_fill = 0;
        m_last = 1'b0;
    endfunction

    // Advance the model by one sample; returns the expected bit
    function automatic logic model_step(int s);
        logic b;
        logic run;
        int   nxt;
        b   = (s >= m_est);
        run = (m_fill == 2) && ((b && m_hist == 2'b11) || (!b && m_hist == 2'b00));
        nxt = b ? m_est + m_step : m_est - m_step;
        if (nxt > 32767)  nxt = 32767;
        if (nxt < -32768) nxt = -32768;
        m_est = nxt;
        if (run) begin
            m_step = m_step + M_INC;
            if (m_step > M_MAX) m_step = M_MAX;
        end else begin
            m_step = m_step - (m_step >>> 5);
            if (m_step < M_MIN) m_step = M_MIN;
        end
        m_hist = {m_hist[0], b};
        if (m_fill < 2) m_fill = m_fill + 1;
        m_last = b;
        return b;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one sample, then check strobe and bit after the edge
    task automatic send(input int s, input string tag);
        logic e;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 16'(s);
        e = model_step(s);
        @(posedge clk);
        #1;
        check("R1 strobe", code_valid, 1'b1);
        check(tag, code_bit, e);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = 16'($urandom);
            @(posedge clk);
            #1;
            check("R1 no strobe", code_valid, 1'b0);
            check("R8 bit held", code_bit, m_last);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R7 reset valid", code_valid, 1'b0);
        check("R7 reset bit", code_bit, 1'b0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        model_reset();
        do_reset();

        // R2: tie at reset estimate 0 gives a 1
        send(0, "R2 tie");
        send(-1, "R2 below");
        send(5, "R2 above");

        // R5: fast ramp forces runs of ones and step growth
        for (int i = 0; i < 60; i++) send(i * 800 - 20000, "R5 ramp");
        // R6: hold a constant so the step decays toward the minimum
        for (int i = 0; i < 200; i++) send(1000, "R6 decay");
        // R3: alternate around the estimate
        for (int i = 0; i < 20; i++) send((i % 2) ? 3000 : -3000, "R3 move");

        // R4: drive to the positive rail, then probe just below it
        for (int i = 0; i < 120; i++) send(32767, "R4 top");
        send(32766, "R4 top probe");
        send(32767, "R4 top");
        // R4: drive to the negative rail, then probe
        for (int i = 0; i < 150; i++) send(-32768, "R4 bottom");
        send(-32767, "R4 bottom probe");

        // R8: idle gaps must not disturb state
        idle(5);
        send(0, "R8 after idle");

        // R7: reset mid-stream, then a tie at 0 again
        for (int i = 0; i < 10; i++) send(20000, "R5 prefill");
        do_reset();
        send(0, "R7 tie after reset");
        send(0, "R7 no run before fill");
        send(0, "R7 third bit");

        // Random samples with random gaps
        for (int i = 0; i < 3000; i++) begin
            int s;
            case ($urandom_range(0, 3))
                0: s = int'($urandom_range(0, 65535)) - 32768;
                1: s = m_est + int'($urandom_range(0, 200)) - 100;
                2: s = (i % 40 < 20) ? 30000 : -30000;
                default: s = m_est;
            endcase
            if (s > 32767)  s = 32767;
            if (s < -32768) s = -32768;
            send(s, "R2 random");
            if ($urandom_range(0, 9) == 0) idle(int'($urandom_range(1, 3)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule